// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the receiving end of the serial bus of a flash memory. It takes chip select, serial clock, hold and serial data from the host, brings them into the system clock domain, and collects bits on rising serial clock edges while the device is selected. The first byte of a frame is the opcode. A built-in table gives, for each opcode, whether a three-byte address follows, how many dummy bytes come after it, and whether data bytes follow. Opcodes that are not in the table make the block ignore the rest of the frame.

When the opcode, and the address if the command has one, have arrived, the block raises a single-cycle command strobe. The strobe carries the opcode, a 21-bit array address and the table fields. The read, program, erase and protection engines downstream act on that strobe. A separate single-cycle pulse marks every rise of chip select, so the engines can close a frame. The hold input pauses the serial transfer without ending the frame. The system clock must run at least four times faster than the serial clock.

Top module: `flash_cmd_front`

## Requirements
- R1: Bits are collected only while chip select is low. A frame begins only when chip select falls, and serial clock activity while chip select is high leaves no trace in the next frame.
- R2: Serial data is taken on each rising serial clock edge. The first byte of a frame is the opcode, received most significant bit first, and it appears unchanged on `cmdOpcode`.
- R3: Each opcode is looked up in the command table. The table gives `cmdDummyBytes` (the number of dummy bytes, 0 to 2) and `cmdHasData` (1 when data bytes follow). Entries with a three-byte address: 1Bh (2 dummy, data), 0Bh, 3Bh (1 dummy, data), 77h (2 dummy, data), 03h, 02h, A2h, 3Ch, 33h, 34h, 35h, 9Bh (0 dummy, data), and 20h, 52h, D8h, 36h, 39h (0 dummy, no data). Entries without an address: 05h, 01h, 31h, F0h, 9Fh (data), and 06h, 04h, B0h, D0h, 60h, C7h, B9h, ABh (no data).
- R4: An opcode that is not in the table raises no command strobe, and no later byte of the same frame raises one either.
- R5: If chip select rises before the opcode and any address are complete, no command strobe is raised.
- R6: The address is received as three bytes, most significant byte first. Bits 23 to 21 are dropped, so `cmdAddr` holds bits 20 to 0.
- R7: `cmdValid` is high for exactly one system clock cycle per accepted frame. For a command with an address it rises after the third address byte. For a command without an address it rises after the opcode, while chip select is still low. Extra bytes after that point raise no further strobe. After reset, `cmdValid`, `frameEnd` and `holdActive` are low.
- R8: `frameEnd` is high for exactly one cycle after each rise of chip select.
- R9: While `holdActive` is high, serial clock edges and serial data are ignored, and the frame continues from the same bit once hold is released. `holdActive` tells the output driver to release its pin.
- R10: A hold begins only when hold is low, chip select is low and the serial clock is low. Hold pulled low while the serial clock is high takes effect only once the clock goes low. Hold pulled low while chip select is high has no effect.
- R11: Frames with the serial clock idling high (mode 3) decode the same as frames with it idling low (mode 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rstN | input | 1 | Asynchronous active-low reset |
| sckIn | input | 1 | Serial clock from the host |
| csNIn | input | 1 | Chip select, active low |
| holdNIn | input | 1 | Hold request, active low |
| siIn | input | 1 | Serial data from the host |
| cmdValid | output | 1 | One-cycle strobe for a decoded command |
| cmdOpcode | output | 8 | Opcode of the current command |
| cmdAddr | output | ADDR_W | Array address with the upper bits dropped |
| cmdDummyBytes | output | 2 | Dummy byte count from the table |
| cmdHasData | output | 1 | Data bytes follow the command |
| frameEnd | output | 1 | One-cycle pulse after chip select rises |
| holdActive | output | 1 | Hold in effect; the output pin must be released |

## Verification
If the bit counter or the frame state drifted, the next opcode would be decoded from a shifted byte. A wrong opcode or a missing strobe would then show up within the same frame, two system cycles after the eighth rising edge. If the sticky ignore state leaked across frames, or were never entered, the command strobe count would be off by the end of the frame that follows. Hold gating errors show up as a corrupted address on the strobe for that same frame. A fault in the hold start rule shows on `holdActive` within three system cycles of the hold input changing.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef struct packed {
    logic       supported;
    logic       hasAddr;
    logic [1:0] dummyBytes;
    logic       hasData;
  } cmdInfo_t;

  typedef struct packed {
    logic frameStart;
    logic latchOp;
    logic shiftAddr;
  } ctrlStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPCODE,
    ST_ADDR,
    ST_PAYLOAD,
    ST_IGNORE
  } frontState_t;

  function automatic cmdInfo_t makeInfo(input logic a, input logic [1:0] d, input logic x);
    cmdInfo_t r;
    r.supported  = 1'b1;
    r.hasAddr    = a;
    r.dummyBytes = d;
    r.hasData    = x;
    return r;
  endfunction

  function automatic cmdInfo_t lookupCmd(input logic [7:0] op);
    cmdInfo_t r;
    r = '0;
    case (op)
      8'h1B, 8'h77:                      r = makeInfo(1'b1, 2'd2, 1'b1);
      8'h0B, 8'h3B:                      r = makeInfo(1'b1, 2'd1, 1'b1);
      8'h03, 8'h02, 8'hA2, 8'h3C,
      8'h33, 8'h34, 8'h35, 8'h9B:        r = makeInfo(1'b1, 2'd0, 1'b1);
      8'h20, 8'h52, 8'hD8, 8'h36, 8'h39: r = makeInfo(1'b1, 2'd0, 1'b0);
      8'h05, 8'h01, 8'h31, 8'hF0, 8'h9F: r = makeInfo(1'b0, 2'd0, 1'b1);
      8'h06, 8'h04, 8'hB0, 8'hD0,
      8'h60, 8'hC7, 8'hB9, 8'hAB:        r = makeInfo(1'b0, 2'd0, 1'b0);
      default:                           r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/flash_cmd_sync.sv
module flash_cmd_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sckIn,
  input  logic csNIn,
  input  logic holdNIn,
  input  logic siIn,
  output logic csActive,
  output logic csFall,
  output logic csRise,
  output logic sckLevel,
  output logic sampleTick,
  output logic siSample,
  output logic holdActive
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sckPipe, csPipe, holdPipe, siPipe;
  logic sckPrev, csPrev;
  logic csLvl, holdLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPipe  <= '0;
      csPipe   <= '1;
      holdPipe <= '1;
      siPipe   <= '0;
      sckPrev  <= 1'b0;
      csPrev   <= 1'b1;
    end else begin
      sckPipe  <= {sckPipe[TOP-1:0], sckIn};
      csPipe   <= {csPipe[TOP-1:0], csNIn};
      holdPipe <= {holdPipe[TOP-1:0], holdNIn};
      siPipe   <= {siPipe[TOP-1:0], siIn};
      sckPrev  <= sckPipe[TOP];
      csPrev   <= csPipe[TOP];
    end
  end

  assign sckLevel = sckPipe[TOP];
  assign csLvl    = csPipe[TOP];
  assign holdLvl  = holdPipe[TOP];
  assign siSample = siPipe[TOP];
  assign csActive = ~csLvl;
  assign csFall   = csPrev & ~csLvl;
  assign csRise   = ~csPrev & csLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdActive <= 1'b0;
    end else if (csLvl || holdLvl) begin
      holdActive <= 1'b0;
    end else if (!sckLevel) begin
      holdActive <= 1'b1;
    end
  end

  assign sampleTick = sckLevel & ~sckPrev & csActive & ~holdActive;
endmodule

// File: rtl/flash_cmd_dp.sv
module flash_cmd_dp
  import flash_cmd_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int ADDR_BYTES = 3,
  parameter int ADDR_W     = 21
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleTick,
  input  logic              siSample,
  input  ctrlStrobe_t       strobe,
  output logic              byteDone,
  output logic [BYTE_W-1:0] rxByte,
  output logic [BYTE_W-1:0] opReg,
  output logic [ADDR_W-1:0] addrOut
);
  localparam int CNT_W   = $clog2(BYTE_W);
  localparam int FULL_W  = ADDR_BYTES * BYTE_W;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  bitCnt;
  logic [FULL_W-1:0] addrReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      rxByte   <= '0;
      byteDone <= 1'b0;
    end else if (strobe.frameStart) begin
      bitCnt   <= '0;
      byteDone <= 1'b0;
    end else if (sampleTick) begin
      rxByte   <= {rxByte[BYTE_W-2:0], siSample};
      bitCnt   <= bitCnt + 1'b1;
      byteDone <= (bitCnt == LAST_BIT);
    end else begin
      byteDone <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg   <= '0;
      addrReg <= '0;
    end else begin
      if (strobe.latchOp)   opReg   <= rxByte;
      if (strobe.shiftAddr) addrReg <= {addrReg[FULL_W-BYTE_W-1:0], rxByte};
    end
  end

  assign addrOut = addrReg[ADDR_W-1:0];
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_BYTES = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csFall,
  input  logic        csRise,
  input  logic        byteDone,
  input  logic [7:0]  rxByte,
  output ctrlStrobe_t strobe,
  output logic        cmdValid,
  output logic        frameEnd
);
  localparam int ACNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [ACNT_W-1:0] LAST_ADDR = ACNT_W'(ADDR_BYTES - 1);

  frontState_t      state, stateNext;
  logic [ACNT_W-1:0] addrCnt, addrCntNext;
  logic              validNext;
  cmdInfo_t          info;

  assign info = lookupCmd(rxByte);

  always_comb begin
    stateNext   = state;
    addrCntNext = addrCnt;
    validNext   = 1'b0;
    strobe      = '0;
    if (csRise) begin
      stateNext = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (csFall) begin
          strobe.frameStart = 1'b1;
          stateNext         = ST_OPCODE;
        end
        ST_OPCODE: if (byteDone) begin
          if (!info.supported) begin
            stateNext = ST_IGNORE;
          end else begin
            strobe.latchOp = 1'b1;
            addrCntNext    = '0;
            if (info.hasAddr) begin
              stateNext = ST_ADDR;
            end else begin
              validNext = 1'b1;
              stateNext = ST_PAYLOAD;
            end
          end
        end
        ST_ADDR: if (byteDone) begin
          strobe.shiftAddr = 1'b1;
          if (addrCnt == LAST_ADDR) begin
            validNext = 1'b1;
            stateNext = ST_PAYLOAD;
          end else begin
            addrCntNext = addrCnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      addrCnt  <= '0;
      cmdValid <= 1'b0;
      frameEnd <= 1'b0;
    end else begin
      state    <= stateNext;
      addrCnt  <= addrCntNext;
      cmdValid <= validNext;
      frameEnd <= csRise;
    end
  end
endmodule

// File: rtl/flash_cmd_front.sv
module flash_cmd_front
  import flash_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_BYTES  = 3,
  parameter int ADDR_W      = 21
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckIn,
  input  logic              csNIn,
  input  logic              holdNIn,
  input  logic              siIn,
  output logic              cmdValid,
  output logic [7:0]        cmdOpcode,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [1:0]        cmdDummyBytes,
  output logic              cmdHasData,
  output logic              frameEnd,
  output logic              holdActive
);
  logic        csActive, csFall, csRise, sckLevel, sampleTick, siSample;
  logic        byteDone;
  logic [7:0]  rxByte;
  ctrlStrobe_t strobe;
  cmdInfo_t    opInfo;

  flash_cmd_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk, .rstN, .sckIn, .csNIn, .holdNIn, .siIn,
    .csActive, .csFall, .csRise, .sckLevel, .sampleTick, .siSample, .holdActive
  );

  flash_cmd_dp #(.BYTE_W(8), .ADDR_BYTES(ADDR_BYTES), .ADDR_W(ADDR_W)) i_dp (
    .clk, .rstN, .sampleTick, .siSample, .strobe,
    .byteDone, .rxByte, .opReg(cmdOpcode), .addrOut(cmdAddr)
  );

  flash_cmd_ctrl #(.ADDR_BYTES(ADDR_BYTES)) i_ctrl (
    .clk, .rstN, .csFall, .csRise, .byteDone, .rxByte,
    .strobe, .cmdValid, .frameEnd
  );

  assign opInfo        = lookupCmd(cmdOpcode);
  assign cmdDummyBytes = opInfo.dummyBytes;
  assign cmdHasData    = opInfo.hasData;
endmodule

// File: rtl/flash_cmd_front_chk.sv
module flash_cmd_front_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdValid,
  input logic       frameEnd,
  input logic       holdActive,
  input logic       csActive,
  input logic       sckLevel,
  input logic [7:0] rxByte
);
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  p_frame_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |-> ($past(csActive, 2) && !$past(csActive)));

  p_valid_in_frame_r1: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> $past(csActive));

  p_hold_start_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdActive) |-> ($past(csActive) && !$past(sckLevel)));

  p_hold_freeze_r9: assert property (@(posedge clk) disable iff (!rstN)
    holdActive |=> $stable(rxByte));
endmodule

bind flash_cmd_front flash_cmd_front_chk i_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .frameEnd(frameEnd),
  .holdActive(holdActive), .csActive(csActive), .sckLevel(sckLevel),
  .rxByte(rxByte)
);

// File: tb/test_flash_cmd_front.sv
module test_flash_cmd_front;
  logic clk = 1'b0, rstN = 1'b0;
  logic sckIn = 1'b0, csNIn = 1'b1, holdNIn = 1'b1, siIn = 1'b0;
  logic        cmdValid, cmdHasData, frameEnd, holdActive;
  logic [7:0]  cmdOpcode;
  logic [20:0] cmdAddr;
  logic [1:0]  cmdDummyBytes;

  always #4 clk = ~clk;

  flash_cmd_front i_flash_cmd_front (
    .clk, .rstN, .sckIn, .csNIn, .holdNIn, .siIn,
    .cmdValid, .cmdOpcode, .cmdAddr, .cmdDummyBytes, .cmdHasData,
    .frameEnd, .holdActive
  );

  int checks = 0, fails = 0;
  int validCnt = 0, frameCnt = 0;
  logic [7:0]  capOp;
  logic [20:0] capAddr;
  logic [1:0]  capDummy;
  logic        capData;
  bit          finished = 1'b0;

  always @(negedge clk) if (rstN) begin
    if (cmdValid) begin
      validCnt++;
      capOp    = cmdOpcode;
      capAddr  = cmdAddr;
      capDummy = cmdDummyBytes;
      capData  = cmdHasData;
    end
    if (frameEnd) frameCnt++;
  end

  // {supported, hasAddr, dummy[1:0], hasData} from the command table in R3
  function automatic logic [4:0] benchInfo(input logic [7:0] op);
    case (op)
      8'h1B, 8'h77: return 5'b11_10_1;
      8'h0B, 8'h3B: return 5'b11_01_1;
      8'h03, 8'h02, 8'hA2, 8'h3C, 8'h33, 8'h34, 8'h35, 8'h9B: return 5'b11_00_1;
      8'h20, 8'h52, 8'hD8, 8'h36, 8'h39: return 5'b11_00_0;
      8'h05, 8'h01, 8'h31, 8'hF0, 8'h9F: return 5'b10_00_1;
      8'h06, 8'h04, 8'hB0, 8'hD0, 8'h60, 8'hC7, 8'hB9, 8'hAB: return 5'b10_00_0;
      default: return 5'b0;
    endcase
  endfunction

  logic [7:0] opList [30] = '{8'h1B, 8'h0B, 8'h03, 8'h3B, 8'h20, 8'h52, 8'hD8, 8'h60,
    8'hC7, 8'h02, 8'hA2, 8'hB0, 8'hD0, 8'h06, 8'h04, 8'h36, 8'h39, 8'h3C, 8'h33, 8'h34,
    8'h35, 8'h9B, 8'h77, 8'h05, 8'h01, 8'h31, 8'hF0, 8'h9F, 8'hB9, 8'hAB};

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input bit b);
    sckIn = 1'b0; siIn = b; tick(4);
    sckIn = 1'b1; tick(4);
  endtask

  task automatic sendByte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
  endtask

  task automatic startFrame(input bit mode3);
    sckIn = mode3; tick(4);
    csNIn = 1'b0; tick(4);
  endtask

  task automatic endFrame(input bit mode3);
    tick(2); sckIn = mode3; tick(4);
    csNIn = 1'b1; tick(8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0]  op;
    logic [23:0] a;
    logic [4:0]  inf;
    int          extra, v0, f0;
    bit          m3;
    void'($urandom(32'h1F2E3D4C));
    tick(3); rstN = 1'b1; tick(2);

    // R7: reset state
    check(cmdValid == 1'b0 && frameEnd == 1'b0 && holdActive == 1'b0, "R7 reset outputs",
          {cmdValid, frameEnd, holdActive}, 3'b000);

    // R1: clocking while deselected leaves no trace
    v0 = validCnt;
    for (int i = 0; i < 11; i++) begin siIn = 1'b1; sckIn = 1'b1; tick(4); sckIn = 1'b0; tick(4); end
    check(validCnt == v0, "R1 no strobe while deselected", validCnt - v0, 0);
    startFrame(1'b0); sendByte(8'h04); endFrame(1'b0);
    check(validCnt - v0 == 1 && capOp == 8'h04, "R1 fresh frame after idle clocking", capOp, 8'h04);

    // R2 R3 R6 R7 R8 R11: random supported commands, mixing modes 0 and 3
    for (int k = 0; k < 40; k++) begin
      op = opList[$urandom_range(0, 29)];
      a = 24'($urandom);
      extra = $urandom_range(0, 2);
      m3 = (k % 3 == 2);
      inf = benchInfo(op);
      v0 = validCnt; f0 = frameCnt;
      startFrame(m3);
      sendByte(op);
      if (inf[3]) for (int j = 2; j >= 0; j--) sendByte(a[j*8 +: 8]);
      for (int j = 0; j < extra; j++) sendByte(8'($urandom));
      endFrame(m3);
      check(validCnt - v0 == 1, m3 ? "R11 R7 one strobe mode 3" : "R7 one strobe", validCnt - v0, 1);
      check(capOp == op, "R2 opcode", capOp, op);
      if (inf[3]) check(capAddr == a[20:0], "R6 address", capAddr, a[20:0]);
      check(capDummy == inf[2:1] && capData == inf[0], "R3 table fields",
            {capDummy, capData}, inf[2:0]);
      check(frameCnt - f0 == 1, "R8 frame end pulse", frameCnt - f0, 1);
    end

    // R4: unsupported opcodes silence the frame
    for (int k = 0; k < 6; k++) begin
      do op = 8'($urandom); while (benchInfo(op)[4]);
      v0 = validCnt; f0 = frameCnt;
      startFrame(1'b0);
      sendByte(op); sendByte(8'h06); sendByte(8'h03); sendByte(8'h12); sendByte(8'h34); sendByte(8'h56);
      endFrame(1'b0);
      check(validCnt == v0, "R4 unsupported opcode ignored", validCnt - v0, 0);
      check(frameCnt - f0 == 1, "R8 frame end after ignored frame", frameCnt - f0, 1);
    end

    // R5: aborted in opcode and in address
    v0 = validCnt;
    startFrame(1'b0);
    for (int i = 0; i < 5; i++) sendBit(1'b0);
    endFrame(1'b0);
    check(validCnt == v0, "R5 abort inside opcode", validCnt - v0, 0);
    startFrame(1'b0); sendByte(8'h20); sendByte(8'h01); sendByte(8'h02); endFrame(1'b0);
    check(validCnt == v0, "R5 abort inside address", validCnt - v0, 0);

    // R7: no-address command strobes before deselect
    v0 = validCnt;
    startFrame(1'b0); sendByte(8'h06); tick(6);
    check(validCnt - v0 == 1, "R7 strobe after opcode while selected", validCnt - v0, 1);
    endFrame(1'b0);

    // R6: top address bits dropped
    startFrame(1'b0); sendByte(8'h03); sendByte(8'hFF); sendByte(8'hFF); sendByte(8'hFF); endFrame(1'b0);
    check(capAddr == 21'h1FFFFF, "R6 upper bits dropped", capAddr, 21'h1FFFFF);

    // R9 R10: hold inside the address phase
    v0 = validCnt;
    startFrame(1'b0); sendByte(8'h02); sendByte(8'h6A);
    holdNIn = 1'b0; tick(6);
    check(holdActive == 1'b0, "R10 no hold while clock high", holdActive, 1'b0);
    sckIn = 1'b0; tick(6);
    check(holdActive == 1'b1, "R10 hold starts once clock low", holdActive, 1'b1);
    for (int i = 0; i < 5; i++) begin siIn = 1'($urandom); sckIn = 1'b1; tick(4); sckIn = 1'b0; tick(4); end
    holdNIn = 1'b1; tick(6);
    check(holdActive == 1'b0, "R9 hold released", holdActive, 1'b0);
    sendByte(8'hBC); sendByte(8'hDE); endFrame(1'b0);
    check(validCnt - v0 == 1 && capAddr == 21'h0ABCDE, "R9 address intact across hold", capAddr, 21'h0ABCDE);

    // R10: hold while deselected has no effect
    holdNIn = 1'b0; tick(8);
    check(holdActive == 1'b0, "R10 no hold while deselected", holdActive, 1'b0);
    holdNIn = 1'b1; tick(4);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule